// File: doc/BRIEF.md
# System-Control Status and Cause Register Unit

This block holds the system-control register bank of a simple in-order processor core. Two of its registers carry behaviour of their own. The status register keeps a six-bit stack of interrupt-enable and kernel-mode pairs in its low bits. Exception entry pushes the stack, and return-from-exception pops it. The cause register records why an exception was taken. It also shows the hardware interrupt lines live, and software can set its two software-interrupt bits. The exception-PC register records where the faulting instruction sat. Every other index is a plain 32-bit storage register.

The core drives one write port and one combinational read port. It pulses `exc_take` with a 5-bit exception code, a delay-slot flag and the faulting PC when it enters an exception. It pulses `ret_exc` when it returns. When software writes the cause register with a software-interrupt bit that is both set and unmasked while interrupts are globally enabled, the block raises `irq_req` for one cycle. Choosing the exception vector and flushing the pipeline are left to the core.

Top module: `sys_ctl_bank`

## Requirements
- R1: After reset, status reads 0, cause reads 0 when `hw_pend` is 0, and `irq_req` is low.
- R2: On `exc_take`, status bits 5:0 become {old bits 3:0, 2'b00} and status bits 31:6 are unchanged.
- R3: On `ret_exc` without `exc_take`, status bits 3:0 take old bits 5:2 and status bits 31:4 are unchanged.
- R4: A write to index 13 (cause) stores the data with bits 15:10 forced to 0. Reads of index 13 always show `hw_pend` in bits 15:10.
- R5: `irq_req` is high in the cycle after an accepted cause write exactly when (write data AND status AND 0x300) is nonzero and status bit 0 is 1. Otherwise it is low.
- R6: An accepted write to any index other than 13 (index 12 = status, 14 = exception PC, all others plain) stores all 32 bits unchanged, and a read returns them.
- R7: On `exc_take`, cause bits 6:2 take `exc_code`, cause bit 31 takes `exc_in_delay`, and the other stored cause bits keep their values. Code 8 taken from a cleared cause with no pending lines reads 0x00000020.
- R8: On `exc_take`, index 14 captures `exc_pc`, or `exc_pc` minus 4 when `exc_in_delay` is 1.
- R9: `exc_take` wins over `ret_exc`, and either strobe causes a write in the same cycle to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index written |
| wr_data | input | 32 | Write data |
| rd_idx | input | 5 | Register index read |
| rd_data | output | 32 | Read data (combinational) |
| ret_exc | input | 1 | Return-from-exception strobe (pops the mode stack) |
| exc_take | input | 1 | Exception-entry strobe |
| exc_code | input | 5 | Exception code loaded into cause bits 6:2 |
| exc_in_delay | input | 1 | Faulting instruction sat in a branch-delay slot |
| exc_pc | input | 32 | PC of the faulting instruction slot |
| hw_pend | input | 6 | Hardware interrupt-pending lines |
| irq_req | output | 1 | One-cycle interrupt request after a cause write |

## Verification
On every cycle the assertions check the stack push and pop on the status register and the code and delay-flag capture in cause. They also check that the stored pending field stays clear, that the live pending lines appear on cause reads, that the exception-PC capture is correct, and that an interrupt request only follows a cause write. Only the bench's scenarios can show full-width storage at the plain indices, and that a write is dropped when it collides with an exception or a return. The same holds for the exact enable-and-mask condition under which a cause write raises a request, and for the literal syscall cause value.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;
  // Low status bits: three enable/mode pairs, pushed by two on exception entry
  localparam int unsigned STK_W    = 6;
  localparam int unsigned STK_STEP = 2;
  // Cause layout
  localparam int unsigned CODE_LO  = 2;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned HW_LO    = 10;
  localparam int unsigned HW_W     = 6;
  localparam logic [31:0] SWI_BITS = 32'h0000_0300;
  // Delay-slot correction applied to the captured PC
  localparam int unsigned SLOT_BYTES = 4;
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_n_s = s1_q;
endmodule

// File: rtl/sc_mode_stack.sv
module sc_mode_stack
  import sys_ctl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 5,
  parameter int STATUS_IDX = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              wr_ok,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] status_q
);
  logic [DATA_W-1:0] status_d;
  logic              wr_hit;
  logic              status_en;

  assign wr_hit    = wr_ok && (wr_idx == IDX_W'(STATUS_IDX));
  assign status_en = push || pop || wr_hit;

  always_comb begin
    status_d = status_q;
    if (push) begin
      status_d[STK_W-1:0] = {status_q[STK_W-STK_STEP-1:0], {STK_STEP{1'b0}}};
    end else if (pop) begin
      status_d[STK_W-STK_STEP-1:0] = status_q[STK_W-1:STK_STEP];
    end else if (wr_hit) begin
      status_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  // R2: push shifts the stack by one pair, upper bits untouched
  p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (status_q[5:0] == {$past(status_q[3:0]), 2'b00}) &&
             (status_q[DATA_W-1:6] == $past(status_q[DATA_W-1:6])));

  // R3: pop restores the previous pair, bits above 3 untouched
  p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (status_q[3:0] == $past(status_q[5:2])) &&
                       (status_q[DATA_W-1:4] == $past(status_q[DATA_W-1:4])));
endmodule

// File: rtl/sc_cause.sv
module sc_cause
  import sys_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_in_delay,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] status_q,
  input  logic [HW_W-1:0]   hw_pend,
  output logic [DATA_W-1:0] cause_view,
  output logic              irq_req
);
  localparam logic [DATA_W-1:0] HW_MASK =
    {{(DATA_W-HW_LO-HW_W){1'b0}}, {HW_W{1'b1}}, {HW_LO{1'b0}}};
  localparam logic [DATA_W-1:0] SWI_MASK = DATA_W'(SWI_BITS);

  logic [DATA_W-1:0] cause_q, cause_d;
  logic              cause_en;
  logic              irq_d;

  assign cause_en = exc_take || wr_hit;

  always_comb begin
    cause_d = cause_q;
    if (exc_take) begin
      cause_d[CODE_LO +: CODE_W] = exc_code;
      cause_d[DATA_W-1]          = exc_in_delay;
    end else if (wr_hit) begin
      cause_d = wr_data & ~HW_MASK;
    end
  end

  assign irq_d = wr_hit && !exc_take && status_q[0] &&
                 (|(wr_data & status_q & SWI_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
    end else begin
      irq_req <= irq_d;
    end
  end

  assign cause_view = cause_q |
    {{(DATA_W-HW_LO-HW_W){1'b0}}, hw_pend, {HW_LO{1'b0}}};

  // R7: entry loads code and delay flag
  p_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (cause_q[CODE_LO +: CODE_W] == $past(exc_code)) &&
                 (cause_q[DATA_W-1] == $past(exc_in_delay)));

  // R4: the stored pending field never holds a software value
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[HW_LO +: HW_W] == '0);

  // R5: a request only follows an accepted cause write
  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(wr_hit));
endmodule

// File: rtl/sc_gp_bank.sv
module sc_gp_bank
  import sys_ctl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 5,
  parameter int STATUS_IDX = 12,
  parameter int CAUSE_IDX  = 13,
  parameter int EPC_IDX    = 14,
  localparam int NREG      = 1 << IDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_ok,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         cap,
  input  logic                         cap_in_delay,
  input  logic [DATA_W-1:0]            cap_pc,
  output logic [NREG-1:0][DATA_W-1:0]  bank_q
);
  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    if (gi == STATUS_IDX || gi == CAUSE_IDX) begin : g_special
      assign bank_q[gi] = '0;
    end else if (gi == EPC_IDX) begin : g_epc
      logic [DATA_W-1:0] epc_q, epc_d;
      logic              epc_en;

      assign epc_en = cap || (wr_ok && (wr_idx == IDX_W'(gi)));

      always_comb begin
        if (cap) begin
          epc_d = cap_in_delay ? (cap_pc - DATA_W'(SLOT_BYTES)) : cap_pc;
        end else begin
          epc_d = wr_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          epc_q <= '0;
        end else if (epc_en) begin
          epc_q <= epc_d;
        end
      end

      assign bank_q[gi] = epc_q;

      // R8: captured PC corrected for the delay slot
      p_epc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> epc_q == ($past(cap_in_delay) ? ($past(cap_pc) - 32'd4)
                                              : $past(cap_pc)));
    end else begin : g_plain
      logic [DATA_W-1:0] val_q;
      logic              val_en;

      assign val_en = wr_ok && (wr_idx == IDX_W'(gi));

      always_ff @(posedge clk) begin
        if (val_en) begin
          val_q <= wr_data;
        end
      end

      assign bank_q[gi] = val_q;
    end
  end
endmodule

// File: rtl/sys_ctl_bank.sv
module sys_ctl_bank
  import sys_ctl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 5,
  parameter int STATUS_IDX = 12,
  parameter int CAUSE_IDX  = 13,
  parameter int EPC_IDX    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ret_exc,
  input  logic              exc_take,
  input  logic [4:0]        exc_code,
  input  logic              exc_in_delay,
  input  logic [DATA_W-1:0] exc_pc,
  input  logic [5:0]        hw_pend,
  output logic              irq_req
);
  localparam int NREG = 1 << IDX_W;

  logic                        rst_n_s;
  logic                        wr_ok;
  logic                        pop;
  logic                        cause_hit;
  logic [DATA_W-1:0]           status_q;
  logic [DATA_W-1:0]           cause_view;
  logic [NREG-1:0][DATA_W-1:0] bank_q;

  // Exception entry beats return; either strobe drops a same-cycle write
  assign wr_ok     = wr_en && !exc_take && !ret_exc;
  assign pop       = ret_exc && !exc_take;
  assign cause_hit = wr_ok && (wr_idx == IDX_W'(CAUSE_IDX));

  sc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  sc_mode_stack #(
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .STATUS_IDX (STATUS_IDX)
  ) u_stack (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .push     (exc_take),
    .pop      (pop),
    .wr_ok    (wr_ok),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .status_q (status_q)
  );

  sc_cause #(
    .DATA_W (DATA_W)
  ) u_cause (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .exc_take     (exc_take),
    .exc_code     (exc_code),
    .exc_in_delay (exc_in_delay),
    .wr_hit       (cause_hit),
    .wr_data      (wr_data),
    .status_q     (status_q),
    .hw_pend      (hw_pend),
    .cause_view   (cause_view),
    .irq_req      (irq_req)
  );

  sc_gp_bank #(
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .STATUS_IDX (STATUS_IDX),
    .CAUSE_IDX  (CAUSE_IDX),
    .EPC_IDX    (EPC_IDX)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .wr_ok        (wr_ok),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .cap          (exc_take),
    .cap_in_delay (exc_in_delay),
    .cap_pc       (exc_pc),
    .bank_q       (bank_q)
  );

  always_comb begin
    if (rd_idx == IDX_W'(STATUS_IDX)) begin
      rd_data = status_q;
    end else if (rd_idx == IDX_W'(CAUSE_IDX)) begin
      rd_data = cause_view;
    end else begin
      rd_data = bank_q[rd_idx];
    end
  end

  // R4: live pending lines visible on every cause read
  p_hwview_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_idx == IDX_W'(CAUSE_IDX)) |-> (rd_data[HW_LO +: HW_W] == hw_pend));
endmodule

// File: tb/sys_ctl_bank_bench.sv
`timescale 1ns/1ps
module sys_ctl_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic        ret_exc;
  logic        exc_take;
  logic [4:0]  exc_code;
  logic        exc_in_delay;
  logic [31:0] exc_pc;
  logic [5:0]  hw_pend;
  logic        irq_req;

  always #4 clk = ~clk;

  sys_ctl_bank u_sys_ctl_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .ret_exc(ret_exc), .exc_take(exc_take),
    .exc_code(exc_code), .exc_in_delay(exc_in_delay), .exc_pc(exc_pc),
    .hw_pend(hw_pend), .irq_req(irq_req)
  );

  // Requirement-level model
  logic [31:0] st_m, ca_m;
  logic [31:0] gp_m [32];
  logic        irq_m;
  int total = 0;
  int bad   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_exp(int idx, logic [5:0] hw);
    if (idx == 12) return st_m;
    if (idx == 13) return ca_m | {16'h0, hw, 10'h0};
    return gp_m[idx];
  endfunction

  task automatic rd(int idx, string tag);
    rd_idx = 5'(idx);
    #1;
    chk(tag, rd_data, rd_exp(idx, hw_pend));
  endtask

  task automatic rd_lit(int idx, logic [31:0] exp, string tag);
    rd_idx = 5'(idx);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic chk_irq(string tag);
    chk(tag, {31'b0, irq_req}, {31'b0, irq_m});
  endtask

  task automatic cyc(bit we, int widx, logic [31:0] wd, bit rf, bit ex,
                     logic [4:0] code, bit bd, logic [31:0] pc);
    wr_en = we; wr_idx = 5'(widx); wr_data = wd;
    ret_exc = rf; exc_take = ex; exc_code = code; exc_in_delay = bd; exc_pc = pc;
    @(posedge clk);
    irq_m = 1'b0;
    if (ex) begin
      st_m[5:0] = {st_m[3:0], 2'b00};
      ca_m[6:2] = code;
      ca_m[31]  = bd;
      gp_m[14]  = bd ? (pc - 32'd4) : pc;
    end else if (rf) begin
      st_m[3:0] = st_m[5:2];
    end else if (we) begin
      if (widx == 13) begin
        irq_m = (|(wd & st_m & 32'h300)) && st_m[0];
        ca_m  = wd & ~32'h0000_FC00;
      end else if (widx == 12) begin
        st_m = wd;
      end else begin
        gp_m[widx] = wd;
      end
    end
    @(negedge clk);
    wr_en = 1'b0; ret_exc = 1'b0; exc_take = 1'b0;
  endtask

  task automatic wr(int widx, logic [31:0] wd);
    cyc(1'b1, widx, wd, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
    ret_exc = 1'b0; exc_take = 1'b0; exc_code = '0; exc_in_delay = 1'b0;
    exc_pc = '0; hw_pend = '0;
    st_m = '0; ca_m = '0; irq_m = 1'b0;
    for (int i = 0; i < 32; i++) gp_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_lit(12, 32'h0, "R1 status after reset");
    rd_lit(13, 32'h0, "R1 cause after reset");
    chk_irq("R1 irq after reset");

    // R6 fill and read back every storage index
    for (int i = 0; i < 32; i++)
      if (i != 12 && i != 13) wr(i, 32'hA500_0000 | 32'(i * 32'h0101_0101));
    for (int i = 0; i < 32; i++)
      if (i != 12 && i != 13) rd(i, "R6 full-width store");

    // R7 R8 syscall-style entry, not in delay slot
    cyc(1'b0, 0, 32'h0, 1'b0, 1'b1, 5'd8, 1'b0, 32'h8000_1000);
    rd_lit(13, 32'h0000_0020, "R7 syscall cause");
    rd_lit(14, 32'h8000_1000, "R8 epc no delay");
    // entry from a delay slot
    cyc(1'b0, 0, 32'h0, 1'b0, 1'b1, 5'd4, 1'b1, 32'h0000_0100);
    rd_lit(13, 32'h8000_0010, "R7 code and delay flag");
    rd_lit(14, 32'h0000_00FC, "R8 epc in delay slot");

    // R3 pop then R2 push
    wr(12, 32'h0000_0A2D);
    cyc(1'b0, 0, 32'h0, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0);
    rd_lit(12, 32'h0000_0A2B, "R3 pop");
    cyc(1'b0, 0, 32'h0, 1'b0, 1'b1, 5'd1, 1'b0, 32'h40);
    rd_lit(12, 32'h0000_0A2C, "R2 push");

    // R4 pending field masking and live view
    wr(13, 32'hFFFF_FFFF);
    chk_irq("R5 no request with global enable clear");
    hw_pend = 6'h00;
    rd_lit(13, 32'hFFFF_03FF, "R4 cleared pending field");
    hw_pend = 6'h2A;
    rd_lit(13, 32'hFFFF_ABFF, "R4 live pending lines");
    hw_pend = 6'h00;

    // R5 request conditions
    wr(12, 32'h0000_0301);
    wr(13, 32'h0000_0100);
    chk(" R5 request raised", {31'b0, irq_req}, 32'd1);
    cyc(1'b0, 0, 32'h0, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0);
    chk(" R5 request is one pulse", {31'b0, irq_req}, 32'd0);
    wr(12, 32'h0000_0201);
    wr(13, 32'h0000_0100);
    chk(" R5 masked bit gives no request", {31'b0, irq_req}, 32'd0);

    // R9 collisions
    cyc(1'b1, 20, 32'hDEAD_BEEF, 1'b0, 1'b1, 5'd2, 1'b0, 32'h200);
    rd(20, "R9 write dropped under exception");
    cyc(1'b1, 12, 32'h0000_FFFF, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0);
    rd(12, "R9 write dropped under return");
    cyc(1'b0, 0, 32'h0, 1'b1, 1'b1, 5'd3, 1'b0, 32'h300);
    rd(12, "R9 exception wins over return");

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      int          kind;
      int          idx;
      bit          we;
      r    = $urandom;
      kind = int'(r[2:0]);
      hw_pend = r[13:8];
      r = $urandom;
      case (r[1:0])
        2'd0: idx = 12;
        2'd1: idx = 13;
        2'd2: idx = 14;
        default: idx = int'(r[6:2]);
      endcase
      we = r[7];
      if (kind == 0)
        cyc(we, idx, $urandom, 1'b0, 1'b1, 5'($urandom), r[8], $urandom);
      else if (kind == 1)
        cyc(we, idx, $urandom, 1'b1, r[9], 5'($urandom), r[8], $urandom);
      else if (kind < 6)
        cyc(1'b1, idx, $urandom, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0);
      else
        cyc(1'b0, 0, 32'h0, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0);
      chk_irq("R5 random request");
      r   = $urandom;
      idx = int'(r[4:0]);
      if (idx == 12)      rd(idx, "R2 R3 random status");
      else if (idx == 13) rd(idx, "R4 R7 random cause");
      else if (idx == 14) rd(idx, "R8 random epc");
      else                rd(idx, "R6 random bank");
    end

    summary();
  end
endmodule